// File: doc/BRIEF.md
# Chip-Enable Write Guard

This block sits on the active-low chip-enable path between a processor and a battery-backed RAM. While the system runs normally, the chip-enable passes straight through. Once the supervisor reports that the system is entering reset, the guard closes the path. From then on, no stray enable produced during a brownout or power cycle can reach the memory.

Reset can arrive while the processor is in the middle of a write. In that case the path is held open for a bounded number of clock cycles so that the write can complete. The path closes early if the processor releases the enable, and closes anyway when the window runs out. A closed guard ignores every new enable until the supervisor releases reset and the incoming enable is seen low at a clock edge.

Top module: `ce_write_guard`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first reopening edge, the guard is closed: `gate_open` is 0 and `ce_out_n` is 1 whatever `ce_in_n` does.
- R2: While the guard is open (`gate_open` = 1) and `sys_rst` is 0, `ce_out_n` equals `ce_in_n` in the same cycle, with no clock delay.
- R3: If a rising clock edge sees `sys_rst` = 1 and `ce_in_n` = 0 while the guard is open, a grace window starts at that edge. The guard stays open for the next GRACE_CYC - 1 edges, and `ce_out_n` keeps following `ce_in_n`.
- R4: If `ce_in_n` goes to 1 during the grace window, `ce_out_n` goes to 1 in that same cycle, and the guard is closed from the next edge on.
- R5: If `ce_in_n` is still 0 when the window runs out, the guard closes at the GRACE_CYC-th edge after the start edge, and `ce_out_n` is forced to 1.
- R6: While the guard is closed and `sys_rst` is 1, the guard stays closed and `ce_out_n` stays 1 for any pattern on `ce_in_n`.
- R7: If an edge sees `sys_rst` = 1 and `ce_in_n` = 1 while the guard is open, the guard closes at that edge and no grace window starts.
- R8: A closed guard reopens at the first edge that sees `sys_rst` = 0 together with `ce_in_n` = 0. If the edge sees `sys_rst` = 0 and `ce_in_n` = 1, the guard stays closed.
- R9: If `sys_rst` returns to 0 during the grace window while `ce_in_n` is 0, the guard goes back to open at that edge, and the window counter no longer closes it. This holds even when the release falls on the edge at which the window would have expired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on clear |
| sys_rst | input | 1 | Supervisor reset state, 1 = system held in reset |
| ce_in_n | input | 1 | Active-low chip-enable from the processor |
| ce_out_n | output | 1 | Gated active-low chip-enable to the RAM |
| gate_open | output | 1 | 1 while the path passes enables (open or in the grace window) |

## Verification
Two functions can meet at one clock edge: the end of the grace window, and the end of the write (or the release of reset). Both race for the same state transition.

The bench lines each of them up on the exact edge where the window counter reaches its limit. In the first case it releases `sys_rst` on that edge and expects the guard to return to open. In the second it raises `ce_in_n` one cycle earlier and expects the output high at once and the guard closed after that edge.

A closed guard is then exercised with enable toggles under reset to show that it does not leak.

// File: rtl/ceg_pkg.sv
package ceg_pkg;

    typedef enum logic [1:0] {
        GATE_CLOSED = 2'd0,
        GATE_OPEN   = 2'd1,
        GATE_GRACE  = 2'd2
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
    } gate_regs_t;

endpackage

// File: rtl/ceg_grace_timer.sv
module ceg_grace_timer #(
    parameter int GRACE_CYC = 1800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = (GRACE_CYC > 1) ? $clog2(GRACE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(GRACE_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.cnt = '0;
        end else if (run && (tmr_q.cnt != LAST)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = (tmr_q.cnt == LAST);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (tmr_q.cnt == '0));

endmodule

// File: rtl/ceg_gate_fsm.sv
module ceg_gate_fsm
    import ceg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sys_rst,
    input  logic        ce_in_n,
    input  logic        expired,
    output gate_state_e state_o,
    output logic        grace_start
);
    gate_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            GATE_OPEN: begin
                if (sys_rst) begin
                    regs_d.state = ce_in_n ? GATE_CLOSED : GATE_GRACE;
                end
            end
            GATE_GRACE: begin
                if (!sys_rst) begin
                    regs_d.state = ce_in_n ? GATE_CLOSED : GATE_OPEN;
                end else if (ce_in_n || expired) begin
                    regs_d.state = GATE_CLOSED;
                end
            end
            default: begin
                if (!sys_rst && !ce_in_n) begin
                    regs_d.state = GATE_OPEN;
                end else begin
                    regs_d.state = GATE_CLOSED;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= GATE_CLOSED;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o     = regs_q.state;
    assign grace_start = (regs_q.state == GATE_OPEN) && sys_rst && !ce_in_n;

    // R3
    grace_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == GATE_OPEN && sys_rst && !ce_in_n) |=> (regs_q.state == GATE_GRACE));

    // R4
    grace_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == GATE_GRACE && sys_rst && ce_in_n) |=> (regs_q.state == GATE_CLOSED));

    // R5
    grace_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == GATE_GRACE && sys_rst && expired) |=> (regs_q.state == GATE_CLOSED));

    // R6
    closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == GATE_CLOSED && sys_rst) |=> (regs_q.state == GATE_CLOSED));

    // R7
    idle_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == GATE_OPEN && sys_rst && ce_in_n) |=> (regs_q.state == GATE_CLOSED));

    // R8
    reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == GATE_CLOSED && !sys_rst && !ce_in_n) |=> (regs_q.state == GATE_OPEN));

    // R9
    grace_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == GATE_GRACE && !sys_rst && !ce_in_n) |=> (regs_q.state == GATE_OPEN));

endmodule

// File: rtl/ce_write_guard.sv
module ce_write_guard
    import ceg_pkg::*;
#(
    parameter int GRACE_CYC = 1800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_rst,
    input  logic ce_in_n,
    output logic ce_out_n,
    output logic gate_open
);
    gate_state_e state;
    logic        grace_start;
    logic        expired;
    logic        passing;

    ceg_gate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sys_rst     (sys_rst),
        .ce_in_n     (ce_in_n),
        .expired     (expired),
        .state_o     (state),
        .grace_start (grace_start)
    );

    ceg_grace_timer #(
        .GRACE_CYC (GRACE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (grace_start),
        .run     (state == GATE_GRACE),
        .expired (expired)
    );

    assign passing   = (state == GATE_OPEN) || (state == GATE_GRACE);
    assign ce_out_n  = passing ? ce_in_n : 1'b1;
    assign gate_open = passing;

    // R1
    closed_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !gate_open);

    // R6
    no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!gate_open) && !gate_open) |-> ce_out_n);

endmodule

// File: tb/test_ce_write_guard.sv
`timescale 1ns/1ps
module test_ce_write_guard;
    localparam int G = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic sys_rst;
    logic ce_in_n;
    logic ce_out_n;
    logic gate_open;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ce_write_guard #(.GRACE_CYC(G)) i_ce_write_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_rst   (sys_rst),
        .ce_in_n   (ce_in_n),
        .ce_out_n  (ce_out_n),
        .gate_open (gate_open)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic reopen();
        sys_rst = 1'b0;
        ce_in_n = 1'b0;
        tick();
        check("R8", "reopen gate_open", gate_open, 1'b1);
    endtask

    task automatic t_power_on();
        rst_n   = 1'b0;
        sys_rst = 1'b1;
        ce_in_n = 1'b0;
        repeat (3) tick();
        check("R1", "clear gate_open", gate_open, 1'b0);
        check("R1", "clear ce_out_n", ce_out_n, 1'b1);
        rst_n = 1'b1;
        repeat (2) tick();
        check("R1", "post-clear under reset gate_open", gate_open, 1'b0);
        check("R1", "post-clear under reset ce_out_n", ce_out_n, 1'b1);
        ce_in_n = 1'b1;
        sys_rst = 1'b0;
        tick();
        check("R8", "release with ce high stays closed", gate_open, 1'b0);
        ce_in_n = 1'b0;
        settle();
        check("R1", "closed before reopen edge ce_out_n", ce_out_n, 1'b1);
        tick();
        check("R8", "reopen on release with ce low", gate_open, 1'b1);
    endtask

    task automatic t_pass_through();
        logic [7:0] pat = 8'b1011_0010;
        for (int i = 0; i < 8; i++) begin
            ce_in_n = pat[i];
            settle();
            check("R2", "follow same cycle", ce_out_n, pat[i]);
            tick();
            check("R2", "follow after edge", ce_out_n, pat[i]);
        end
        ce_in_n = 1'b0;
        tick();
    endtask

    task automatic t_grace_expire();
        ce_in_n = 1'b0;
        sys_rst = 1'b1;
        tick();
        check("R3", "grace start gate_open", gate_open, 1'b1);
        for (int k = 1; k < G; k++) begin
            ce_in_n = 1'b0;
            tick();
            check("R3", "inside window gate_open", gate_open, 1'b1);
            check("R3", "inside window ce_out_n", ce_out_n, 1'b0);
        end
        tick();
        check("R5", "window end gate_open", gate_open, 1'b0);
        check("R5", "window end ce_out_n", ce_out_n, 1'b1);
        for (int k = 0; k < 4; k++) begin
            ce_in_n = k[0];
            settle();
            check("R6", "closed ignores ce", ce_out_n, 1'b1);
            tick();
            check("R6", "closed stays closed", gate_open, 1'b0);
        end
    endtask

    task automatic t_grace_abort();
        reopen();
        sys_rst = 1'b1;
        tick();
        repeat (3) tick();
        check("R3", "abort setup still open", gate_open, 1'b1);
        ce_in_n = 1'b1;
        settle();
        check("R4", "ce release same cycle ce_out_n", ce_out_n, 1'b1);
        tick();
        check("R4", "closed after release edge", gate_open, 1'b0);
        ce_in_n = 1'b0;
        settle();
        check("R6", "re-enable ignored ce_out_n", ce_out_n, 1'b1);
        tick();
        check("R6", "re-enable ignored gate_open", gate_open, 1'b0);
    endtask

    task automatic t_idle_reset();
        reopen();
        ce_in_n = 1'b1;
        tick();
        sys_rst = 1'b1;
        tick();
        check("R7", "idle reset closes at once", gate_open, 1'b0);
        ce_in_n = 1'b0;
        settle();
        check("R7", "no grace window ce_out_n", ce_out_n, 1'b1);
        tick();
        check("R7", "no grace window gate_open", gate_open, 1'b0);
    endtask

    task automatic t_release_in_grace();
        reopen();
        sys_rst = 1'b1;
        tick();
        repeat (2) tick();
        sys_rst = 1'b0;
        tick();
        check("R9", "release mid window", gate_open, 1'b1);
        repeat (G + 2) tick();
        check("R9", "no late close after release", gate_open, 1'b1);
        check("R9", "pass-through after release", ce_out_n, 1'b0);
    endtask

    task automatic t_release_at_expiry();
        reopen();
        sys_rst = 1'b1;
        tick();
        for (int k = 1; k < G; k++) tick();
        sys_rst = 1'b0;
        tick();
        check("R9", "release on expiry edge wins", gate_open, 1'b1);
    endtask

    task automatic t_ce_high_at_expiry();
        reopen();
        sys_rst = 1'b1;
        tick();
        for (int k = 1; k < G - 1; k++) tick();
        ce_in_n = 1'b1;
        settle();
        check("R4", "release before expiry ce_out_n", ce_out_n, 1'b1);
        tick();
        check("R4", "closed after release before expiry", gate_open, 1'b0);
        ce_in_n = 1'b0;
        tick();
        check("R6", "stays closed past expiry", ce_out_n, 1'b1);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        sys_rst = 1'b1;
        ce_in_n = 1'b1;
        @(negedge clk);
        t_power_on();
        t_pass_through();
        t_grace_expire();
        t_grace_abort();
        t_idle_reset();
        t_release_in_grace();
        t_release_at_expiry();
        t_ce_high_at_expiry();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule